// File: doc/BRIEF.md
# Parallel NOR program/erase sequencer

This block writes a run of bytes into a byte-wide parallel NOR flash. A single start request carries a start offset, a byte count and an addressing variant. The variant selects which pair of unlock addresses the command cycles use. The block first erases every 64 KiB sector that the range touches. It then issues one flash reset cycle and programs the bytes one at a time, taking them from a valid/ready byte stream. A final reset cycle ends the run. An external status poller is asked to confirm every sector erase and every byte program before the sequencer moves on. The run ends with a one-cycle done pulse and a two-bit result code.

The flash bus is a single-cycle write strobe with address and data. A ready input from the bus side lets the sequencer stall between any two cycles. The control is one state machine with these states:
- IDLE waits for a start.
- ER_CYC issues the six erase cycles, ER_REQ raises the poll request and ER_WAIT waits for the poll result.
- RST_ER issues the reset that follows the erase pass.
- PG_FETCH takes the next byte, PG_CYC issues the four program cycles, PG_REQ raises the poll request and PG_WAIT waits for the poll result.
- RST_PG issues the closing reset, and DONE pulses done.

The transitions are:
- IDLE goes to ER_CYC, RST_ER or DONE.
- ER_CYC goes to ER_REQ after its last cycle, and ER_REQ goes to ER_WAIT.
- ER_WAIT goes back to ER_CYC when a further sector remains. Otherwise it goes to RST_ER, or to DONE on a failure.
- RST_ER goes to PG_FETCH, or to RST_PG when the count is zero.
- PG_FETCH goes to PG_CYC, PG_CYC goes to PG_REQ, and PG_REQ goes to PG_WAIT.
- PG_WAIT goes back to PG_FETCH when bytes remain. Otherwise it goes to RST_PG, or to DONE on a failure.
- RST_PG goes to DONE, and DONE goes to IDLE.

Top module: `nor_pgm_seq`

## Requirements
- R1: The variant select value 2'b01 uses unlock addresses 0xAAA (first) and 0x555 (second). The value 2'b10 uses 0x555 (first) and 0x2AA (second). All addresses are offsets from the flash base.
- R2: Each byte is programmed by four write cycles in this order: 0xAA at the first unlock address, 0x55 at the second, 0xA0 at the first, then the data byte at start offset plus byte index. The bytes are taken from the stream in order.
- R3: Each sector erase is six write cycles in this order: 0xAA at the first unlock address, 0x55 at the second, 0x80 at the first, 0xAA at the first, 0x55 at the second, then 0x30 at the sector address.
- R4: The first sector address is the start offset with its low 16 bits cleared. Erase repeats in steps of 0x10000 while the sector address is below start plus count, computed without wrap. A zero count with an unaligned start therefore still erases one sector.
- R5: Every erase happens before any programming. A reset cycle (0xF0 written at offset 0) follows the erase pass, and another follows the last programmed byte.
- R6: After the last cycle of each erase or program command, poll_req is high for one cycle. poll_addr gives the sector or the byte offset, and poll_erase is 1 for an erase and 0 for a program. No write cycle occurs from poll_req until poll_done is seen.
- R7: A poll result with poll_fail during an erase ends the run with err_code 2. No further bus cycles occur.
- R8: A poll result with poll_fail during a program ends the run with err_code 3. No further bus cycles occur.
- R9: A start with variant 2'b00 or 2'b11 causes no bus cycle. done is high in the cycle after start, with err_code 1.
- R10: busy rises in the cycle after an accepted start and stays high through the done cycle. A start while busy is ignored.
- R11: bus_we is high only in cycles where bus_rdy is high. A low bus_rdy holds the pending cycle until bus_rdy returns.
- R12: done is high for exactly one cycle. err_code is 0 after a successful run and is held until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start request, sampled in IDLE |
| start_off | input | AW | First target offset |
| byte_cnt | input | AW | Number of bytes to program |
| variant | input | 2 | Unlock address variant select |
| src_valid | input | 1 | Stream byte available |
| src_data | input | 8 | Stream byte |
| src_ready | output | 1 | Stream byte taken this cycle |
| bus_we | output | 1 | Single-cycle flash write strobe |
| bus_addr | output | AW | Flash write offset |
| bus_wdata | output | 8 | Flash write data |
| bus_rdy | input | 1 | Bus can take a write this cycle |
| poll_req | output | 1 | Start a status poll |
| poll_erase | output | 1 | Poll is for an erase (1) or a program (0) |
| poll_addr | output | AW | Sector or byte offset being polled |
| poll_done | input | 1 | Poll finished |
| poll_fail | input | 1 | Poll finished with failure |
| busy | output | 1 | Run in progress |
| done | output | 1 | Run finished pulse |
| err_code | output | 2 | 0 ok, 1 parameter, 2 erase fail, 3 write fail |

## Verification
A parameter error is checked by seeing done and err_code 1 in the first cycle after the start edge. busy is checked in that same cycle for valid runs. poll_req is due in the cycle after the final write of each command, and writes can resume at the earliest in the cycle after poll_done. The bench therefore logs bus writes and poll requests on the rising edge, using the same values the design samples, and compares the whole ordered log with a sequence it builds from the requirements. done and err_code come from registered state, so they are read on the falling edge when done first appears, and again one cycle later to confirm the pulse has ended.

// File: rtl/nor_seq_pkg.sv
package nor_seq_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_ER_CYC,
        S_ER_REQ,
        S_ER_WAIT,
        S_RST_ER,
        S_PG_FETCH,
        S_PG_CYC,
        S_PG_REQ,
        S_PG_WAIT,
        S_RST_PG,
        S_DONE
    } seq_state_t;

    typedef enum logic [1:0] {
        OP_ERASE,
        OP_PROG,
        OP_RESET
    } bus_op_t;

    localparam logic [1:0] VAR_A     = 2'b01;
    localparam logic [1:0] VAR_B     = 2'b10;

    localparam logic [1:0] ERR_NONE  = 2'd0;
    localparam logic [1:0] ERR_PARAM = 2'd1;
    localparam logic [1:0] ERR_ERASE = 2'd2;
    localparam logic [1:0] ERR_WRITE = 2'd3;

    localparam logic [7:0] CMD_KEY1   = 8'hAA;
    localparam logic [7:0] CMD_KEY2   = 8'h55;
    localparam logic [7:0] CMD_PROG   = 8'hA0;
    localparam logic [7:0] CMD_ERSET  = 8'h80;
    localparam logic [7:0] CMD_SECTOR = 8'h30;
    localparam logic [7:0] CMD_RESET  = 8'hF0;

endpackage

// File: rtl/nor_unlock_map.sv
module nor_unlock_map #(
    parameter int AW = 24
) (
    input  logic [1:0]    variant,
    output logic [AW-1:0] key_addr1,
    output logic [AW-1:0] key_addr2,
    output logic          var_ok
);
    import nor_seq_pkg::*;

    always_comb begin
        key_addr1 = '0;
        key_addr2 = '0;
        var_ok    = 1'b0;
        unique case (variant)
            VAR_A: begin
                key_addr1 = AW'(12'hAAA);
                key_addr2 = AW'(12'h555);
                var_ok    = 1'b1;
            end
            VAR_B: begin
                key_addr1 = AW'(12'h555);
                key_addr2 = AW'(12'h2AA);
                var_ok    = 1'b1;
            end
            default: var_ok = 1'b0;
        endcase
    end

endmodule

// File: rtl/nor_cycle_gen.sv
module nor_cycle_gen #(
    parameter int AW = 24
) (
    input  nor_seq_pkg::bus_op_t op,
    input  logic [2:0]           step,
    input  logic [AW-1:0]        key_addr1,
    input  logic [AW-1:0]        key_addr2,
    input  logic [AW-1:0]        sect_addr,
    input  logic [AW-1:0]        byte_addr,
    input  logic [7:0]           byte_data,
    output logic [AW-1:0]        cyc_addr,
    output logic [7:0]           cyc_data,
    output logic                 cyc_last
);
    import nor_seq_pkg::*;

    always_comb begin
        cyc_addr = '0;
        cyc_data = CMD_RESET;
        cyc_last = 1'b0;
        unique case (op)
            OP_ERASE: begin
                unique case (step)
                    3'd0: begin cyc_addr = key_addr1; cyc_data = CMD_KEY1;  end
                    3'd1: begin cyc_addr = key_addr2; cyc_data = CMD_KEY2;  end
                    3'd2: begin cyc_addr = key_addr1; cyc_data = CMD_ERSET; end
                    3'd3: begin cyc_addr = key_addr1; cyc_data = CMD_KEY1;  end
                    3'd4: begin cyc_addr = key_addr2; cyc_data = CMD_KEY2;  end
                    default: begin
                        cyc_addr = sect_addr;
                        cyc_data = CMD_SECTOR;
                        cyc_last = 1'b1;
                    end
                endcase
            end
            OP_PROG: begin
                unique case (step)
                    3'd0: begin cyc_addr = key_addr1; cyc_data = CMD_KEY1; end
                    3'd1: begin cyc_addr = key_addr2; cyc_data = CMD_KEY2; end
                    3'd2: begin cyc_addr = key_addr1; cyc_data = CMD_PROG; end
                    default: begin
                        cyc_addr = byte_addr;
                        cyc_data = byte_data;
                        cyc_last = 1'b1;
                    end
                endcase
            end
            default: begin
                cyc_addr = '0;
                cyc_data = CMD_RESET;
                cyc_last = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/nor_pgm_seq.sv
module nor_pgm_seq #(
    parameter int AW        = 24,
    parameter int SECT_BITS = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [AW-1:0] start_off,
    input  logic [AW-1:0] byte_cnt,
    input  logic [1:0]    variant,
    input  logic          src_valid,
    input  logic [7:0]    src_data,
    output logic          src_ready,
    output logic          bus_we,
    output logic [AW-1:0] bus_addr,
    output logic [7:0]    bus_wdata,
    input  logic          bus_rdy,
    output logic          poll_req,
    output logic          poll_erase,
    output logic [AW-1:0] poll_addr,
    input  logic          poll_done,
    input  logic          poll_fail,
    output logic          busy,
    output logic          done,
    output logic [1:0]    err_code
);
    import nor_seq_pkg::*;

    localparam int            CW        = AW + 1;
    localparam logic [CW-1:0] SECT_STEP = CW'(1) << SECT_BITS;
    localparam logic [CW-1:0] SECT_MASK = ~(SECT_STEP - CW'(1));

    seq_state_t    state, state_nx;
    logic [2:0]    step_q;
    logic [1:0]    var_q;
    logic [CW-1:0] sec_q, end_q;
    logic [AW-1:0] tgt_q, rem_q;
    logic [7:0]    data_q;
    logic [1:0]    err_q;

    logic [1:0]    var_sel;
    logic [AW-1:0] key1, key2;
    logic          var_ok;
    bus_op_t       op;
    logic          wr_active;
    logic [AW-1:0] cyc_addr;
    logic [7:0]    cyc_data;
    logic          cyc_last;
    logic [CW-1:0] first_sec, range_end, sec_next;

    assign var_sel   = (state == S_IDLE) ? variant : var_q;
    assign first_sec = {1'b0, start_off} & SECT_MASK;
    assign range_end = {1'b0, start_off} + {1'b0, byte_cnt};
    assign sec_next  = sec_q + SECT_STEP;

    nor_unlock_map #(.AW(AW)) u_map (
        .variant   (var_sel),
        .key_addr1 (key1),
        .key_addr2 (key2),
        .var_ok    (var_ok)
    );

    nor_cycle_gen #(.AW(AW)) u_cyc (
        .op        (op),
        .step      (step_q),
        .key_addr1 (key1),
        .key_addr2 (key2),
        .sect_addr (sec_q[AW-1:0]),
        .byte_addr (tgt_q),
        .byte_data (data_q),
        .cyc_addr  (cyc_addr),
        .cyc_data  (cyc_data),
        .cyc_last  (cyc_last)
    );

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE: begin
                if (start) begin
                    if (!var_ok)                 state_nx = S_DONE;
                    else if (first_sec < range_end) state_nx = S_ER_CYC;
                    else                         state_nx = S_RST_ER;
                end
            end
            S_ER_CYC:  if (bus_we && cyc_last) state_nx = S_ER_REQ;
            S_ER_REQ:  state_nx = S_ER_WAIT;
            S_ER_WAIT: begin
                if (poll_done) begin
                    if (poll_fail)             state_nx = S_DONE;
                    else if (sec_next < end_q) state_nx = S_ER_CYC;
                    else                       state_nx = S_RST_ER;
                end
            end
            S_RST_ER: begin
                if (bus_we) state_nx = (rem_q == '0) ? S_RST_PG : S_PG_FETCH;
            end
            S_PG_FETCH: if (src_valid) state_nx = S_PG_CYC;
            S_PG_CYC:   if (bus_we && cyc_last) state_nx = S_PG_REQ;
            S_PG_REQ:   state_nx = S_PG_WAIT;
            S_PG_WAIT: begin
                if (poll_done) begin
                    if (poll_fail)              state_nx = S_DONE;
                    else if (rem_q == AW'(1))   state_nx = S_RST_PG;
                    else                        state_nx = S_PG_FETCH;
                end
            end
            S_RST_PG: if (bus_we) state_nx = S_DONE;
            S_DONE:   state_nx = S_IDLE;
            default:  state_nx = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            step_q <= '0;
            var_q  <= '0;
            sec_q  <= '0;
            end_q  <= '0;
            tgt_q  <= '0;
            rem_q  <= '0;
            data_q <= '0;
            err_q  <= ERR_NONE;
        end else begin
            unique case (state)
                S_IDLE: begin
                    if (start) begin
                        step_q <= '0;
                        if (var_ok) begin
                            var_q <= variant;
                            sec_q <= first_sec;
                            end_q <= range_end;
                            tgt_q <= start_off;
                            rem_q <= byte_cnt;
                            err_q <= ERR_NONE;
                        end else begin
                            err_q <= ERR_PARAM;
                        end
                    end
                end
                S_ER_CYC, S_PG_CYC: begin
                    if (bus_we) step_q <= cyc_last ? 3'd0 : step_q + 3'd1;
                end
                S_ER_WAIT: begin
                    if (poll_done) begin
                        if (poll_fail) err_q <= ERR_ERASE;
                        else           sec_q <= sec_next;
                    end
                end
                S_PG_FETCH: if (src_valid) data_q <= src_data;
                S_PG_WAIT: begin
                    if (poll_done) begin
                        if (poll_fail) err_q <= ERR_WRITE;
                        else begin
                            tgt_q <= tgt_q + AW'(1);
                            rem_q <= rem_q - AW'(1);
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        wr_active  = 1'b0;
        op         = OP_RESET;
        src_ready  = 1'b0;
        poll_req   = 1'b0;
        poll_erase = 1'b0;
        unique case (state)
            S_ER_CYC:   begin wr_active = 1'b1; op = OP_ERASE; end
            S_ER_REQ:   begin poll_req = 1'b1; poll_erase = 1'b1; end
            S_ER_WAIT:  poll_erase = 1'b1;
            S_RST_ER:   wr_active = 1'b1;
            S_PG_FETCH: src_ready = 1'b1;
            S_PG_CYC:   begin wr_active = 1'b1; op = OP_PROG; end
            S_PG_REQ:   poll_req = 1'b1;
            S_RST_PG:   wr_active = 1'b1;
            default: ;
        endcase
        bus_we    = wr_active & bus_rdy;
        bus_addr  = cyc_addr;
        bus_wdata = cyc_data;
        poll_addr = poll_erase ? sec_q[AW-1:0] : tgt_q;
        busy      = (state != S_IDLE);
        done      = (state == S_DONE);
        err_code  = err_q;
    end

    // R9
    param_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE && start && !var_ok) |=> (done && err_code == ERR_PARAM && !bus_we));

    // R6
    poll_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        poll_req |-> $past(bus_we));

    // R4
    erase_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && state == S_ER_CYC && cyc_last) |-> (sec_q < end_q));

    // R2
    prog_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && state == S_PG_CYC && cyc_last) |-> (bus_addr == tgt_q && bus_wdata == data_q));

    // R10
    busy_from_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));

    // R12
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

endmodule

// File: tb/tb_nor_pgm_seq.sv
`timescale 1ns/1ps
module tb_nor_pgm_seq;
    import nor_seq_pkg::*;

    localparam int AW = 24;

    typedef struct packed {
        logic [1:0]  v;
        logic [23:0] s;
        logic [7:0]  n;
        logic [7:0]  f;
    } vec_t;

    localparam int NVEC = 9;
    localparam vec_t VECS [NVEC] = '{
        '{2'b01, 24'h000010, 8'd3, 8'hFF},
        '{2'b10, 24'h01FFFE, 8'd4, 8'hFF},
        '{2'b01, 24'h020000, 8'd0, 8'hFF},
        '{2'b10, 24'h030005, 8'd0, 8'hFF},
        '{2'b01, 24'h01FFFF, 8'd2, 8'd1},
        '{2'b10, 24'h000100, 8'd5, 8'd3},
        '{2'b00, 24'h000000, 8'd2, 8'hFF},
        '{2'b11, 24'h040000, 8'd1, 8'hFF},
        '{2'b01, 24'hFFFFFE, 8'd2, 8'hFF}
    };

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [AW-1:0] start_off = '0;
    logic [AW-1:0] byte_cnt = '0;
    logic [1:0]    variant = '0;
    logic          src_valid = 1'b0;
    logic [7:0]    src_data = '0;
    logic          src_ready;
    logic          bus_we;
    logic [AW-1:0] bus_addr;
    logic [7:0]    bus_wdata;
    logic          bus_rdy = 1'b0;
    logic          poll_req;
    logic          poll_erase;
    logic [AW-1:0] poll_addr;
    logic          poll_done = 1'b0;
    logic          poll_fail = 1'b0;
    logic          busy;
    logic          done;
    logic [1:0]    err_code;

    nor_pgm_seq #(.AW(AW), .SECT_BITS(16)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .start_off(start_off),
        .byte_cnt(byte_cnt), .variant(variant), .src_valid(src_valid),
        .src_data(src_data), .src_ready(src_ready), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdy(bus_rdy),
        .poll_req(poll_req), .poll_erase(poll_erase), .poll_addr(poll_addr),
        .poll_done(poll_done), .poll_fail(poll_fail), .busy(busy),
        .done(done), .err_code(err_code)
    );

    int checks = 0;
    int fails = 0;
    bit finished = 1'b0;

    logic [AW-1:0] exp_a [128];
    logic [8:0]    exp_d [128];
    int            exp_n;
    logic [1:0]    exp_err;
    logic [AW-1:0] log_a [128];
    logic [8:0]    log_d [128];
    int            log_n = 0;

    int  bidx = 0;
    int  pk = 0;
    int  fail_at = -1;
    int  pcnt = 0;
    bit  ppend = 1'b0;
    bit  in_poll = 1'b0;
    int  viol_rdy = 0;
    int  viol_poll = 0;
    int  stalls = 0;
    logic [15:0] lfsr = 16'hACE1;

    function automatic logic [7:0] pat(int i);
        return 8'hA5 ^ 8'(i * 29);
    endfunction

    task automatic chk(bit ok, string tag, string what, int act, int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, expv);
        end
    endtask

    task automatic add_exp(logic [AW-1:0] a, logic [8:0] d);
        exp_a[exp_n] = a;
        exp_d[exp_n] = d;
        exp_n++;
    endtask

    task automatic build_exp(vec_t v);
        logic [AW-1:0] u1, u2;
        logic [AW:0]   sec, lim;
        int            k;
        exp_n = 0;
        k = 0;
        if (v.v == 2'b01)      begin u1 = 24'hAAA; u2 = 24'h555; end
        else if (v.v == 2'b10) begin u1 = 24'h555; u2 = 24'h2AA; end
        else begin exp_err = 2'd1; return; end
        sec = {1'b0, v.s} & ~25'h00FFFF;
        lim = {1'b0, v.s} + 25'(v.n);
        while (sec < lim) begin
            add_exp(u1, 9'h0AA); add_exp(u2, 9'h055); add_exp(u1, 9'h080);
            add_exp(u1, 9'h0AA); add_exp(u2, 9'h055); add_exp(sec[AW-1:0], 9'h030);
            add_exp(sec[AW-1:0], 9'h101);
            if (k == int'(v.f)) begin exp_err = 2'd2; return; end
            k++;
            sec = sec + 25'h010000;
        end
        add_exp('0, 9'h0F0);
        for (int i = 0; i < int'(v.n); i++) begin
            add_exp(u1, 9'h0AA); add_exp(u2, 9'h055); add_exp(u1, 9'h0A0);
            add_exp(v.s + AW'(i), {1'b0, pat(i)});
            add_exp(v.s + AW'(i), 9'h100);
            if (k == int'(v.f)) begin exp_err = 2'd3; return; end
            k++;
        end
        add_exp('0, 9'h0F0);
        exp_err = 2'd0;
    endtask

    // input models, driven away from the active edge
    always @(negedge clk) begin
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        bus_rdy   = lfsr[0] | lfsr[3];
        src_valid = lfsr[5] | lfsr[7];
        src_data  = pat(bidx);
        if (poll_done) begin poll_done = 1'b0; poll_fail = 1'b0; end
        if (ppend) begin
            pcnt--;
            if (pcnt == 0) begin
                poll_done = 1'b1;
                poll_fail = (pk == fail_at);
                pk++;
                ppend = 1'b0;
            end
        end
        if (poll_req) begin ppend = 1'b1; pcnt = 1 + (pk % 3); end
    end

    // monitor, samples what the design samples
    always @(posedge clk) begin
        if (rst_n) begin
            if (bus_we) begin
                if (!bus_rdy) viol_rdy++;
                if (in_poll)  viol_poll++;
                if (log_n < 128) begin log_a[log_n] = bus_addr; log_d[log_n] = {1'b0, bus_wdata}; end
                log_n++;
            end
            if (busy && !bus_rdy) stalls++;
            if (poll_req) begin
                if (log_n < 128) begin log_a[log_n] = poll_addr; log_d[log_n] = {1'b1, 7'd0, poll_erase}; end
                log_n++;
                in_poll = 1'b1;
            end
            if (poll_done) in_poll = 1'b0;
            if (src_valid && src_ready) bidx++;
        end
    end

    function automatic string tag_of(vec_t v);
        if (v.v == 2'b00 || v.v == 2'b11) return "R9";
        if (v.f == 8'hFF) return "R1/R2/R3/R4/R5/R6";
        return (v.f == 8'd1) ? "R7" : "R8";
    endfunction

    task automatic run_vec(vec_t v, bit inject);
        int  cyc;
        int  bad;
        bit  valid;
        string tag;
        tag = inject ? "R10" : tag_of(v);
        valid = (v.v == 2'b01 || v.v == 2'b10);
        build_exp(v);
        log_n = 0; bidx = 0; pk = 0;
        fail_at = (v.f == 8'hFF) ? -1 : int'(v.f);
        @(negedge clk);
        start = 1'b1; start_off = v.s; byte_cnt = AW'(v.n); variant = v.v;
        @(negedge clk);
        start = 1'b0;
        if (valid) chk(busy == 1'b1, "R10", "busy one cycle after start", int'(busy), 1);
        else       chk(done == 1'b1 && log_n == 0, "R9", "done one cycle after start", int'(done), 1);
        cyc = 0;
        while (!done && cyc < 20000) begin
            if (inject && cyc == 8) begin
                start = 1'b1; start_off = 24'h500000; byte_cnt = 24'd9; variant = VAR_B;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
            cyc++;
        end
        start = 1'b0;
        chk(done == 1'b1, "R12", "done reached", int'(done), 1);
        chk(err_code == exp_err, tag, "result code", int'(err_code), int'(exp_err));
        chk(busy == 1'b1, "R10", "busy during done", int'(busy), 1);
        @(negedge clk);
        chk(done == 1'b0 && busy == 1'b0, "R12", "done single cycle", int'(done), 0);
        chk(err_code == exp_err, "R12", "result code held", int'(err_code), int'(exp_err));
        repeat (4) @(negedge clk);
        bad = -1;
        for (int i = 0; i < exp_n && i < log_n && i < 128; i++)
            if (bad < 0 && (log_a[i] !== exp_a[i] || log_d[i] !== exp_d[i])) bad = i;
        if (bad < 0 && log_n != exp_n) bad = (log_n < exp_n) ? log_n : exp_n;
        if (bad < 0) chk(1'b1, tag, "bus sequence", 0, 0);
        else if (bad < exp_n && bad < log_n)
            chk(1'b0, tag, $sformatf("bus sequence entry %0d", bad),
                int'({log_a[bad], log_d[bad]}), int'({exp_a[bad], exp_d[bad]}));
        else
            chk(1'b0, tag, "bus sequence length", log_n, exp_n);
    endtask

    initial begin
        #(4 * 190000);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(busy == 1'b0 && done == 1'b0 && bus_we == 1'b0 && poll_req == 1'b0,
            "R12", "outputs idle in reset", int'({busy, done, bus_we, poll_req}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(err_code == 2'd0 && busy == 1'b0, "R12", "reset state after release",
            int'({busy, err_code}), 0);
        for (int i = 0; i < NVEC; i++) run_vec(VECS[i], 1'b0);
        // start while busy must not disturb the run in progress
        run_vec(VECS[0], 1'b1);
        chk(viol_rdy == 0, "R11", "write without bus ready", viol_rdy, 0);
        chk(stalls > 0, "R11", "stall cycles exercised", stalls > 0, 1);
        chk(viol_poll == 0, "R6", "write during poll", viol_poll, 0);
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule